// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is a half-duplex serial port that moves one byte at a time over a single data line, paced by a shift clock it generates itself from the system clock. The system clock stands for the oscillator: every bit occupies a fixed slot of oscillator periods. The shift clock sits high while nothing is moving.

Software starts a transmit by writing a byte to the buffer. The port then drives the byte onto the data line, least significant bit first, and sets a transmit-done flag when the eighth bit is out. Software starts a receive by clearing the receive-done flag. The port then keeps the data line undriven, samples it at each rising edge of the shift clock, and sets the receive-done flag once the eighth bit is in. The received byte can then be read from the buffer output.

A start request that arrives while a byte is moving has no effect. Each done flag stays set until software clears it.

Top module: `sync_shift_port`

## Requirements
- R1: While reset is held and right after it is released, sck is high, sdo_oe is low, sdo is high, tx_done and rx_done are low, and buf_rdata is zero.
- R2: A buf_wr pulse seen on a rising clk edge while the port is idle starts a transmit. From that edge on, sdo_oe is high and sdo carries bit 0 of buf_wdata.
- R3: During a transfer, each bit slot lasts 12 clk cycles, counted as phases 0 to 11 from the slot's first edge. sck is low for phases 4 to 9 and high for phases 10, 11 and 0 to 3.
- R4: On a transmit, the bit of slot k is buf_wdata[k], with slots 0 to 7 in order. sdo changes only at the start of a slot: 10 cycles before the sck rise and 2 cycles after the previous rise.
- R5: On a transmit, 96 cycles after the start edge tx_done goes high, sdo_oe goes low, sdo returns high and sck is high.
- R6: An rx_flag_clr pulse seen while the port is idle starts a receive. sdo_oe stays low for the whole receive.
- R7: On a receive, sdi is sampled at the clk edge on which sck goes from low to high, which is the phase 9 to phase 10 edge. The bit of slot k lands in bit k of the result, and the value of sdi at any other time has no effect.
- R8: On a receive, 96 cycles after the start edge rx_done goes high and buf_rdata holds the received byte. buf_rdata changes at no other time.
- R9: While a transfer is in progress, buf_wr and rx_flag_clr neither restart nor alter it, and they start nothing after it ends.
- R10: tx_done and rx_done stay high until tx_flag_clr or rx_flag_clr respectively is seen. That pulse clears the flag on the next edge.
- R11: If buf_wr and rx_flag_clr arrive on the same idle edge, a transmit starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| buf_wr | input | 1 | Buffer write strobe; starts a transmit |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rdata | output | 8 | Last byte received |
| tx_flag_clr | input | 1 | Clears tx_done |
| rx_flag_clr | input | 1 | Clears rx_done; starts a receive when idle |
| tx_done | output | 1 | Transmit complete flag |
| rx_done | output | 1 | Receive complete flag |
| sck | output | 1 | Shift clock, idles high |
| sdo | output | 1 | Data line output value |
| sdo_oe | output | 1 | Data line output enable |
| sdi | input | 1 | Data line input value |

## Verification
The hardest point to pin down from the ports is the exact receive sampling instant. A port that samples one cycle early or late still assembles a plausible byte when the input is steady. The bench therefore drives the true bit onto sdi only during the single cycle before the sck rise and drives random bits in every other cycle of the slot, so only a sampler on the rising-edge cycle recovers the byte. The bench also fires start requests in the middle of transfers and on the same idle edge. Together these reach the ignore rules and the transmit-first rule.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2
    } ssp_mode_e;
endpackage

// File: rtl/ssp_seq.sv
module ssp_seq
    import ssp_pkg::*;
#(
    parameter int SLOT_LEN = 12,
    parameter int FALL_PH  = 4,
    parameter int RISE_PH  = 10,
    parameter int NBITS    = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_tx,
    input  logic      start_rx,
    output ssp_mode_e mode,
    output logic      load_tx,
    output logic      tx_shift,
    output logic      rx_sample,
    output logic      tx_finish,
    output logic      rx_finish,
    output logic      sck
);
    localparam int PH_W  = $clog2(SLOT_LEN);
    localparam int BIT_W = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(SLOT_LEN - 1);
    localparam logic [PH_W-1:0]  PRE_RISE = PH_W'(RISE_PH - 1);
    localparam logic [PH_W-1:0]  LOW_LO   = PH_W'(FALL_PH);
    localparam logic [PH_W-1:0]  LOW_HI   = PH_W'(RISE_PH);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NBITS - 1);

    typedef struct packed {
        ssp_mode_e        mode;
        logic [PH_W-1:0]  ph;
        logic [BIT_W-1:0] bitn;
        logic             sck;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        load_tx   = 1'b0;
        tx_shift  = 1'b0;
        rx_sample = 1'b0;
        tx_finish = 1'b0;
        rx_finish = 1'b0;
        case (seq_q.mode)
            MODE_IDLE: begin
                seq_d.ph   = '0;
                seq_d.bitn = '0;
                if (start_tx) begin
                    seq_d.mode = MODE_TX;
                    load_tx    = 1'b1;
                end else if (start_rx) begin
                    seq_d.mode = MODE_RX;
                end
            end
            default: begin
                if (seq_q.ph == LAST_PH) begin
                    seq_d.ph = '0;
                    if (seq_q.bitn == LAST_BIT) begin
                        seq_d.mode = MODE_IDLE;
                        seq_d.bitn = '0;
                        tx_finish  = (seq_q.mode == MODE_TX);
                        rx_finish  = (seq_q.mode == MODE_RX);
                    end else begin
                        seq_d.bitn = seq_q.bitn + 1'b1;
                        tx_shift   = (seq_q.mode == MODE_TX);
                    end
                end else begin
                    seq_d.ph  = seq_q.ph + 1'b1;
                    rx_sample = (seq_q.mode == MODE_RX) && (seq_q.ph == PRE_RISE);
                end
            end
        endcase
        if (seq_d.mode == MODE_IDLE) begin
            seq_d.sck = 1'b1;
        end else begin
            seq_d.sck = !((seq_d.ph >= LOW_LO) && (seq_d.ph < LOW_HI));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.mode <= MODE_IDLE;
            seq_q.ph   <= '0;
            seq_q.bitn <= '0;
            seq_q.sck  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mode = seq_q.mode;
    assign sck  = seq_q.sck;
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_tx,
    input  logic             tx_shift,
    input  logic             rx_sample,
    input  logic             rx_finish,
    input  logic             tx_active,
    input  logic [NBITS-1:0] wdata,
    input  logic             sdi,
    output logic             sdo,
    output logic [NBITS-1:0] rdata
);
    typedef struct packed {
        logic [NBITS-1:0] shreg;
        logic [NBITS-1:0] rbuf;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (load_tx) begin
            dp_d.shreg = wdata;
        end else if (tx_shift) begin
            dp_d.shreg = {1'b0, dp_q.shreg[NBITS-1:1]};
        end else if (rx_sample) begin
            dp_d.shreg = {sdi, dp_q.shreg[NBITS-1:1]};
        end
        if (rx_finish) begin
            dp_d.rbuf = dp_q.shreg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q.shreg <= '0;
            dp_q.rbuf  <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign sdo   = tx_active ? dp_q.shreg[0] : 1'b1;
    assign rdata = dp_q.rbuf;
endmodule

// File: rtl/ssp_flags.sv
module ssp_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_set,
    input  logic rx_set,
    input  logic tx_clr,
    input  logic rx_clr,
    output logic tx_flag,
    output logic rx_flag
);
    typedef struct packed {
        logic tx;
        logic rx;
    } flg_t;

    flg_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (tx_clr) flg_d.tx = 1'b0;
        if (rx_clr) flg_d.rx = 1'b0;
        if (tx_set) flg_d.tx = 1'b1;
        if (rx_set) flg_d.rx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign tx_flag = flg_q.tx;
    assign rx_flag = flg_q.rx;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SLOT_LEN = 12,
    parameter int FALL_PH  = 4,
    parameter int RISE_PH  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    output logic [DATA_W-1:0] buf_rdata,
    input  logic              tx_flag_clr,
    input  logic              rx_flag_clr,
    output logic              tx_done,
    output logic              rx_done,
    output logic              sck,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi
);
    ssp_mode_e mode;
    logic load_tx, tx_shift, rx_sample, tx_finish, rx_finish;

    ssp_seq #(
        .SLOT_LEN(SLOT_LEN),
        .FALL_PH (FALL_PH),
        .RISE_PH (RISE_PH),
        .NBITS   (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_tx (buf_wr),
        .start_rx (rx_flag_clr),
        .mode     (mode),
        .load_tx  (load_tx),
        .tx_shift (tx_shift),
        .rx_sample(rx_sample),
        .tx_finish(tx_finish),
        .rx_finish(rx_finish),
        .sck      (sck)
    );

    assign sdo_oe = (mode == MODE_TX);

    ssp_datapath #(.NBITS(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_tx  (load_tx),
        .tx_shift (tx_shift),
        .rx_sample(rx_sample),
        .rx_finish(rx_finish),
        .tx_active(sdo_oe),
        .wdata    (buf_wdata),
        .sdi      (sdi),
        .sdo      (sdo),
        .rdata    (buf_rdata)
    );

    ssp_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_set (tx_finish),
        .rx_set (rx_finish),
        .tx_clr (tx_flag_clr),
        .rx_clr (rx_flag_clr),
        .tx_flag(tx_done),
        .rx_flag(rx_done)
    );
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              tx_done,
    input logic              rx_done,
    input logic              tx_flag_clr,
    input logic              rx_flag_clr,
    input logic [DATA_W-1:0] buf_rdata
);
    AST_SDO_CHANGE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> (sck && $past(sck) && $past(sck, 2))); // R4

    AST_SCK_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |=> !sck); // R3

    AST_TX_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (sck && !sdo_oe && sdo)); // R5

    AST_RX_DONE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> (!sdo_oe && sck)); // R6

    AST_RDATA_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_rdata) |-> $rose(rx_done)); // R8

    AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_flag_clr) |=> tx_done); // R10

    AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_flag_clr) |=> rx_done); // R10
endmodule

bind sync_shift_port ssp_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .tx_done    (tx_done),
    .rx_done    (rx_done),
    .tx_flag_clr(tx_flag_clr),
    .rx_flag_clr(rx_flag_clr),
    .buf_rdata  (buf_rdata)
);

// File: tb/sync_shift_port_tb.sv
`timescale 1ns/1ps
module sync_shift_port_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       buf_wr;
    logic [7:0] buf_wdata;
    logic [7:0] buf_rdata;
    logic       tx_flag_clr;
    logic       rx_flag_clr;
    logic       tx_done;
    logic       rx_done;
    logic       sck;
    logic       sdo;
    logic       sdo_oe;
    logic       sdi;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sync_shift_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .buf_rdata  (buf_rdata),
        .tx_flag_clr(tx_flag_clr),
        .rx_flag_clr(rx_flag_clr),
        .tx_done    (tx_done),
        .rx_done    (rx_done),
        .sck        (sck),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .sdi        (sdi)
    );

    function automatic logic exp_sck(input int ph);
        return !((ph >= 4) && (ph <= 9));
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input int n);
        return d[n / 12];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t act=%0h exp=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic idle_checks(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check("R9 idle sck", sck, 1'b1);
            check("R9 idle oe", sdo_oe, 1'b0);
        end
    endtask

    // both=1 also raises rx_flag_clr on the start edge (R11)
    task automatic run_tx(input logic [7:0] d, input bit inject, input bit both);
        @(negedge clk);
        buf_wr = 1'b1;
        buf_wdata = d;
        rx_flag_clr = both;
        for (int n = 0; n <= 96; n++) begin
            @(negedge clk);
            if (n == 0) begin
                buf_wr = 1'b0;
                rx_flag_clr = 1'b0;
                buf_wdata = ~d;
            end
            if (inject && n == 30) begin
                buf_wr = 1'b1;
                rx_flag_clr = 1'b1;
            end
            if (inject && n == 31) begin
                buf_wr = 1'b0;
                rx_flag_clr = 1'b0;
            end
            if (n < 96) begin
                check(both ? "R11 tx oe" : "R2 tx oe", sdo_oe, 1'b1);
                check("R3 tx sck", sck, exp_sck(n % 12));
                check(inject ? "R9 tx sdo" : "R4 tx sdo", sdo, exp_bit(d, n));
                check("R5 tx_done low", tx_done, 1'b0);
            end else begin
                check("R5 end oe", sdo_oe, 1'b0);
                check("R5 end sdo", sdo, 1'b1);
                check("R5 end sck", sck, 1'b1);
                check("R5 tx_done", tx_done, 1'b1);
            end
        end
        idle_checks(4);
        check("R10 tx_done held", tx_done, 1'b1);
        tx_flag_clr = 1'b1;
        @(negedge clk);
        tx_flag_clr = 1'b0;
        check("R10 tx_done cleared", tx_done, 1'b0);
    endtask

    task automatic run_rx(input logic [7:0] d, input bit inject);
        @(negedge clk);
        rx_flag_clr = 1'b1;
        for (int n = 0; n <= 96; n++) begin
            @(negedge clk);
            if (n == 0) rx_flag_clr = 1'b0;
            if (n < 96) begin
                // true bit only in the cycle before the sck rise, noise elsewhere
                sdi = ((n % 12) == 9) ? d[n / 12] : 1'($urandom);
                if (inject && n == 40) begin
                    buf_wr = 1'b1;
                    buf_wdata = 8'hFF;
                end
                if (inject && n == 41) buf_wr = 1'b0;
                check("R6 rx oe", sdo_oe, 1'b0);
                check("R3 rx sck", sck, exp_sck(n % 12));
                check("R8 rx_done low", rx_done, 1'b0);
            end else begin
                check("R8 rx_done", rx_done, 1'b1);
                check(inject ? "R9 rx byte" : "R7 rx byte", buf_rdata, d);
                check("R8 end sck", sck, 1'b1);
            end
        end
        idle_checks(3);
        check("R10 rx_done held", rx_done, 1'b1);
        check("R8 rdata stable", buf_rdata, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed);
        rst_n = 1'b0;
        buf_wr = 1'b0;
        buf_wdata = 8'h00;
        tx_flag_clr = 1'b0;
        rx_flag_clr = 1'b0;
        sdi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 sck", sck, 1'b1);
        check("R1 oe", sdo_oe, 1'b0);
        check("R1 sdo", sdo, 1'b1);
        check("R1 flags", {tx_done, rx_done}, 2'b00);
        check("R1 rdata", buf_rdata, 8'h00);
        rst_n = 1'b1;
        idle_checks(2);
        check("R1 flags after release", {tx_done, rx_done}, 2'b00);

        run_tx(8'hA5, 1'b0, 1'b0);
        run_tx(8'h01, 1'b1, 1'b0);
        run_tx(8'h80, 1'b0, 1'b1);
        run_rx(8'h3C, 1'b0);
        run_rx(8'h81, 1'b1);
        run_rx(8'h00, 1'b0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            if ($urandom % 2 == 0) run_tx(v, 1'($urandom), 1'b0);
            else                   run_rx(v, 1'($urandom));
        end
        summary();
    end
endmodule